// File: doc/BRIEF.md
# Memory Module Configuration Port Block

This block is the byte-wide I/O register front end of a memory controller with six module sockets. Firmware uses it to find out which sockets are populated and whether each module is the small (8 MB) or large (32 MB) kind. It then programs the end address of each memory bank. A downstream address decoder consumes those end addresses.

The size of each socket arrives as a two-bit strap. Two read-only ports expose the straps: an identification port marks the large modules, and a presence port marks the empty sockets. A single shared sizing port carries the end addresses. A write to it selects the target entry from the top three bits of the data byte. A read walks through the eight entries with an internal pointer that advances on every read. Reading the presence port rewinds that pointer to entry 0. A fixed status port reports that no parity error was seen.

Each read side effect happens once per rising edge of the read strobe. Read data is registered and is held until the next read begins.

Top module: `simm_cfg_regs`

## Requirements
- R1: After synchronous reset, all eight end-address entries on `end_addr_o` are 0, `io_rdata_o` is 0, and the read pointer is 0, so the first sizing-port read returns 0x00.
- R2: A read of port 0x803 returns bit n = 1 exactly when socket n carries strap code 2'b10 (32 MB). Bits 7:6 are 0.
- R3: A read of port 0x804 returns 0xFF with bit n cleared when socket n carries strap code 2'b01 (8 MB) or 2'b10 (32 MB). Codes 2'b00 and 2'b11 count as empty.
- R4: A write to port 0x820 stores data bits 4:0 into entry data[7:5]. The value appears on `end_addr_o[5*k +: 5]` for entry k after the write's clock edge.
- R5: Each read of port 0x820 returns {3'b000, entry[pointer]} and then advances the pointer by one, wrapping from 7 to 0.
- R6: Any read of port 0x804 sets the read pointer to 0.
- R7: A read of port 0x841 returns 0x01.
- R8: Writes to ports 0x803, 0x804, 0x841 or to any unmapped address leave all end-address entries unchanged.
- R9: A read of an unmapped address returns 0xFF.
- R10: A read strobe held high for several cycles causes its side effect (pointer advance or rewind) only once.
- R11: `io_rdata_o` is updated one clock after the rising edge of `io_rd_i` and holds its value until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 12 | Per-socket size code, socket n at bits 2n+1:2n |
| io_addr_i | input | 12 | I/O port address |
| io_rd_i | input | 1 | Read strobe |
| io_wr_i | input | 1 | Write strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| end_addr_o | output | 40 | Eight 5-bit end-address entries, entry k at bits 5k+4:5k |

## Verification
The status ports are read under two strap patterns. The second pattern mixes all four codes across the sockets, so the reserved code is shown to read as empty and the identification and presence bits are shown to belong to the right socket. All eight entries are written with distinct values and then read back ten times in a row. This separates a correct index decode from an aliased one and shows the wrap from 7 to 0. A held read strobe, writes to read-only and unmapped ports, and presence reads placed between sizing reads separate the single-shot side effect, write filtering and pointer rewind from their faulty variants.

// File: rtl/simm_cfg_pkg.sv
package simm_cfg_pkg;
  parameter int unsigned NSOCK = 6;
  parameter int unsigned NENT  = 8;
  parameter int unsigned EW    = 5;
  parameter int unsigned AW    = 12;
  parameter int unsigned DW    = 8;

  parameter logic [11:0] PORT_ID     = 12'h803;
  parameter logic [11:0] PORT_PRES   = 12'h804;
  parameter logic [11:0] PORT_SIZE   = 12'h820;
  parameter logic [11:0] PORT_PARITY = 12'h841;

  parameter logic [7:0] PARITY_OK  = 8'h01;
  parameter logic [7:0] UNMAPPED_V = 8'hFF;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_8M   = 2'b01,
    SZ_32M  = 2'b10,
    SZ_RSVD = 2'b11
  } strap_t;
endpackage

// File: rtl/simm_rd_edge.sv
module simm_rd_edge (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  output logic pulse_o
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_i;
  end

  assign pulse_o = rd_i & ~rd_q;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R10
endmodule

// File: rtl/simm_strap_decode.sv
module simm_strap_decode
  import simm_cfg_pkg::*;
#(
  parameter int unsigned N_SOCK = NSOCK,
  parameter int unsigned D_W    = DW
) (
  input  logic [2*N_SOCK-1:0] strap_i,
  output logic [D_W-1:0]      id_o,
  output logic [D_W-1:0]      pres_o
);
  localparam int unsigned PAD = D_W - N_SOCK;

  logic [N_SOCK-1:0] big_v;
  logic [N_SOCK-1:0] occ_v;

  for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
    strap_t code;
    assign code     = strap_t'(strap_i[2*s +: 2]);
    assign big_v[s] = (code == SZ_32M);
    assign occ_v[s] = (code == SZ_32M) || (code == SZ_8M);
  end

  assign id_o   = {{PAD{1'b0}}, big_v};
  assign pres_o = {{PAD{1'b1}}, ~occ_v};
endmodule

// File: rtl/simm_end_table.sv
module simm_end_table #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned E_W   = 5,
  localparam int unsigned IW   = $clog2(N_ENT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [E_W-1:0]     wr_val,
  input  logic               rd_adv,
  input  logic               ptr_clr,
  output logic [E_W-1:0]     rd_val_o,
  output logic [N_ENT*E_W-1:0] tbl_o
);
  logic [E_W-1:0] tbl_q [N_ENT];
  logic [IW-1:0]  ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_ENT; k++) tbl_q[k] <= '0;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (ptr_clr) ptr_q <= '0;
    else if (rd_adv)  ptr_q <= ptr_q + 1'b1;
  end

  assign rd_val_o = tbl_q[ptr_q];

  for (genvar k = 0; k < N_ENT; k++) begin : g_flat
    assign tbl_o[k*E_W +: E_W] = tbl_q[k];
  end

  AST_WR_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_val)); // R4
  AST_PTR_ADV: assert property (@(posedge clk) disable iff (rst)
    (rd_adv && !ptr_clr) |=> ptr_q == IW'($past(ptr_q) + 1'b1)); // R5
  AST_PTR_CLR: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> ptr_q == '0); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_adv && !ptr_clr) |=> $stable(ptr_q)); // R10
endmodule

// File: rtl/simm_cfg_regs.sv
module simm_cfg_regs
  import simm_cfg_pkg::*;
#(
  parameter int unsigned N_SOCK = NSOCK,
  parameter int unsigned N_ENT  = NENT,
  parameter int unsigned E_W    = EW,
  parameter int unsigned A_W    = AW,
  parameter int unsigned D_W    = DW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*N_SOCK-1:0]    strap_i,
  input  logic [A_W-1:0]         io_addr_i,
  input  logic                   io_rd_i,
  input  logic                   io_wr_i,
  input  logic [D_W-1:0]         io_wdata_i,
  output logic [D_W-1:0]         io_rdata_o,
  output logic [N_ENT*E_W-1:0]   end_addr_o
);
  localparam int unsigned IW = $clog2(N_ENT);

  logic           rd_pulse;
  logic [D_W-1:0] id_byte;
  logic [D_W-1:0] pres_byte;
  logic [E_W-1:0] size_val;
  logic           hit_id, hit_pres, hit_size, hit_par;
  logic [D_W-1:0] rd_mux;

  assign hit_id   = (io_addr_i == A_W'(PORT_ID));
  assign hit_pres = (io_addr_i == A_W'(PORT_PRES));
  assign hit_size = (io_addr_i == A_W'(PORT_SIZE));
  assign hit_par  = (io_addr_i == A_W'(PORT_PARITY));

  simm_rd_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (io_rd_i),
    .pulse_o (rd_pulse)
  );

  simm_strap_decode #(.N_SOCK(N_SOCK), .D_W(D_W)) u_dec (
    .strap_i (strap_i),
    .id_o    (id_byte),
    .pres_o  (pres_byte)
  );

  simm_end_table #(.N_ENT(N_ENT), .E_W(E_W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (io_wr_i && hit_size),
    .wr_idx   (io_wdata_i[D_W-1 -: IW]),
    .wr_val   (io_wdata_i[E_W-1:0]),
    .rd_adv   (rd_pulse && hit_size),
    .ptr_clr  (rd_pulse && hit_pres),
    .rd_val_o (size_val),
    .tbl_o    (end_addr_o)
  );

  always_comb begin
    if (hit_id)        rd_mux = id_byte;
    else if (hit_pres) rd_mux = pres_byte;
    else if (hit_size) rd_mux = D_W'(size_val);
    else if (hit_par)  rd_mux = D_W'(PARITY_OK);
    else               rd_mux = D_W'(UNMAPPED_V);
  end

  always_ff @(posedge clk) begin
    if (rst)           io_rdata_o <= '0;
    else if (rd_pulse) io_rdata_o <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_pulse |=> $stable(io_rdata_o)); // R11
  AST_PARITY_OK: assert property (@(posedge clk) disable iff (rst)
    (rd_pulse && hit_par) |=> io_rdata_o == D_W'(8'h01)); // R7
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    (rd_pulse && !hit_id && !hit_pres && !hit_size && !hit_par)
      |=> io_rdata_o == {D_W{1'b1}}); // R9
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (io_wr_i && !hit_size) |=> $stable(end_addr_o)); // R8
endmodule

// File: tb/simm_cfg_regs_tb.sv
`timescale 1ns/1ps
module simm_cfg_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] strap_i;
  logic [11:0] io_addr_i;
  logic        io_rd_i;
  logic        io_wr_i;
  logic [7:0]  io_wdata_i;
  logic [7:0]  io_rdata_o;
  logic [39:0] end_addr_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [4:0] m_tbl [8];
  logic [2:0] m_ptr;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  simm_cfg_regs dut_i (
    .clk(clk), .rst(rst), .strap_i(strap_i), .io_addr_i(io_addr_i),
    .io_rd_i(io_rd_i), .io_wr_i(io_wr_i), .io_wdata_i(io_wdata_i),
    .io_rdata_o(io_rdata_o), .end_addr_o(end_addr_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected bytes on each rising read strobe.
  logic rd_last = 1'b0;
  initial begin
    forever begin
      logic fire;
      @(posedge clk);
      fire = io_rd_i && !rd_last && !rst;
      rd_last = io_rd_i;
      if (fire) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL scoreboard: actual %0h expected none", io_rdata_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, io_rdata_o, e);
        end
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [11:0] a);
    logic [7:0] v;
    if (a == 12'h803) begin
      v = 8'h00;
      for (int n = 0; n < 6; n++) if (strap_i[2*n +: 2] == 2'b10) v[n] = 1'b1;
    end else if (a == 12'h804) begin
      v = 8'hFF;
      for (int n = 0; n < 6; n++)
        if (strap_i[2*n +: 2] == 2'b01 || strap_i[2*n +: 2] == 2'b10) v[n] = 1'b0;
      m_ptr = 3'd0;
    end else if (a == 12'h820) begin
      v = {3'b000, m_tbl[m_ptr]};
      m_ptr = m_ptr + 3'd1;
    end else if (a == 12'h841) begin
      v = 8'h01;
    end else begin
      v = 8'hFF;
    end
    return v;
  endfunction

  task automatic rd(input logic [11:0] a, input int hold, input string tag);
    logic [7:0] e;
    e = model_read(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    io_addr_i = a;
    io_rd_i = 1'b1;
    @(negedge clk);
    for (int h = 1; h < hold; h++) begin
      @(negedge clk);
      check("R11 held read data", io_rdata_o, e);
    end
    io_rd_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input string tag);
    io_addr_i = a;
    io_wdata_i = d;
    io_wr_i = 1'b1;
    @(negedge clk);
    io_wr_i = 1'b0;
    if (a == 12'h820) m_tbl[d[7:5]] = d[4:0];
    for (int k = 0; k < 8; k++) check(tag, end_addr_o[5*k +: 5], m_tbl[k]);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m_tbl[k] = 5'd0;
    m_ptr = 3'd0;
    rst = 1'b1;
    io_rd_i = 1'b0; io_wr_i = 1'b0; io_addr_i = 12'h000; io_wdata_i = 8'h00;
    // sockets 0,1: 32 MB; 2,3: 8 MB; 4,5 empty
    strap_i = {2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 end addresses after reset", end_addr_o, 40'd0);
    check("R1 read data after reset", io_rdata_o, 8'h00);
    rd(12'h820, 1, "R1 first size read");
    rd(12'h804, 1, "R3 R6 presence pattern A");
    rd(12'h803, 1, "R2 id pattern A");

    for (int i = 0; i < 8; i++)
      wr(12'h820, {3'(i), 5'((i * 7 + 3) & 31)}, "R4 indexed write");

    rd(12'h804, 1, "R6 presence rewinds pointer");
    for (int i = 0; i < 10; i++) rd(12'h820, 1, "R5 sequential size read with wrap");

    rd(12'h804, 1, "R6 rewind before held read");
    rd(12'h820, 4, "R10 held size read");
    rd(12'h820, 1, "R10 next entry after held read");
    rd(12'h804, 3, "R10 held presence read");
    rd(12'h820, 1, "R6 entry 0 after held presence");

    wr(12'h803, 8'hFF, "R8 write to id port ignored");
    wr(12'h804, 8'hE0, "R8 write to presence port ignored");
    wr(12'h841, 8'h5A, "R8 write to parity port ignored");
    wr(12'h123, 8'hFF, "R8 write to unmapped port ignored");

    rd(12'h841, 1, "R7 parity status");
    rd(12'h100, 1, "R9 unmapped read");
    rd(12'h820, 1, "R5 pointer unaffected by other reads");

    // mixed codes incl. reserved on socket 3
    strap_i = {2'b01, 2'b10, 2'b11, 2'b10, 2'b00, 2'b01};
    rd(12'h803, 1, "R2 id pattern B");
    rd(12'h804, 1, "R3 presence pattern B");
    rd(12'h820, 1, "R6 entry 0 after pattern B presence");

    wr(12'h820, 8'hBF, "R4 overwrite entry 5");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) m_tbl[k] = 5'd0;
    m_ptr = 3'd0;
    check("R1 end addresses after second reset", end_addr_o, 40'd0);
    rd(12'h820, 1, "R1 entry 0 after second reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule